// File: doc/BRIEF.md
# Time-Slot Subchannel Gate

This block connects one HDLC controller's serial bit stream to a single time slot of a TDM frame. Each slot holds eight bit positions. A per-slot validation mask picks which of those positions belong to the subchannel. In full-rate mode the chosen positions are used in every frame. In half-rate mode receive uses them only in every second frame. Transmit sends its bits in that same frame and then replays them unchanged in the frame after it.

Data has two possible routes. In the first, receive comes from switching-matrix output 6 and transmit goes to matrix input 6. In the second, a direct pin pair carries the data: a dedicated input pin feeds receive, and a dedicated output pin carries the transmitter. While direct access is off, that output pin carries matrix output 7. A global option keeps the transmitter tied to matrix input 6 at all times. The block also drives the pull-down enable of an open-drain contention bus and flags collisions against the echo input when the carrier-sense mode is on.

The frame, slot and bit counters come from outside the block, and each clock cycle is one bit time. The frame sync pulse is high during bit 0 of slot 0.

Top module: `tdm_subchan_gate`

## Requirements
- R1: From reset until the first frame sync, tx_req, rx_stb, cbus_pd and collision stay 0, mx_in6 stays 1 and pin_dout follows mx_out7. The first frame after reset counts as an even frame.
- R2: A bit time is validated when slot_idx equals cfg_slot and bit cfg_mask[bit_idx] is 1. Bit i of the mask belongs to bit position i. tx_req and rx_stb are never high outside validated bit times, and each is high for at most one cycle per bit.
- R3: With cfg_half at 0, every validated bit time of every frame asserts both tx_req and rx_stb.
- R4: With cfg_half at 1, frame parity alternates at each frame sync. tx_req and rx_stb are asserted only for validated bit times of even frames.
- R5: With cfg_half at 1, in an odd frame the transmit data at a validated position is the tx_bit value taken at that position in the previous frame.
- R6: rx_bit equals pin_din when cfg_direct is 1 and mx_out6 when it is 0.
- R7: pin_dout carries the transmit data during validated bit times when cfg_direct is 1. At all other times it equals mx_out7.
- R8: mx_in6 carries the transmit data during validated bit times when cfg_tx_fixed is 1 or cfg_direct is 0. At all other times it is 1.
- R9: cbus_pd (1 = pull the bus low) is 1 only during a validated bit time whose transmit data is 0, and only when cfg_csma is 1 or cfg_cbus_en is 1. Otherwise the bus is released, and cfg_cbus_en has no effect while cfg_csma is 1.
- R10: collision is 1 during a validated bit time when cfg_csma is 1 and echo_in differs from the transmit data. It is never 1 while cfg_csma is 0, because echo_in is then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one bit time per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync | input | 1 | Frame sync, high during slot 0 bit 0 |
| slot_idx | input | SLOT_W | Current slot number |
| bit_idx | input | BIT_W | Current bit position within the slot |
| cfg_slot | input | SLOT_W | Slot assigned to the subchannel |
| cfg_mask | input | BITS | Validated bit positions of that slot |
| cfg_half | input | 1 | Half-rate mode |
| cfg_direct | input | 1 | Route through the direct pin pair |
| cfg_tx_fixed | input | 1 | Keep transmitter on matrix input 6 |
| cfg_csma | input | 1 | Carrier-sense contention mode |
| cfg_cbus_en | input | 1 | Contention bus enable when not in carrier-sense mode |
| tx_bit | input | 1 | Transmit bit from the HDLC controller |
| tx_req | output | 1 | Transmit bit taken this cycle |
| rx_bit | output | 1 | Receive bit to the HDLC controller |
| rx_stb | output | 1 | Receive bit valid this cycle |
| mx_out6 | input | 1 | Matrix output 6 data |
| mx_out7 | input | 1 | Matrix output 7 data |
| mx_in6 | output | 1 | Data to matrix input 6 |
| pin_din | input | 1 | Direct receive pin |
| pin_dout | output | 1 | Direct/transmit output pin |
| echo_in | input | 1 | Contention bus echo |
| cbus_pd | output | 1 | Open-drain pull-down enable |
| collision | output | 1 | Echo mismatch flag |

## Verification
The hardest case to reach is the odd frame in half-rate mode. There the outputs depend on bits stored one frame earlier, and the stored bits depend on which mask and mode were active at that time. The bench keeps each configuration for four whole frames, so every configuration starts on an even frame. It then sweeps every combination of the mode bits against several masks, with random serial data on every input. It keeps its own per-position copy of the last taken transmit bit to predict each replay.

// File: rtl/tdm_subchan_gate.sv
module tdm_subchan_gate #(
  parameter int SLOTS = 32,
  parameter int BITS  = 8,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int BIT_W  = $clog2(BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic [SLOT_W-1:0] slot_idx,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [BITS-1:0]   cfg_mask,
  input  logic              cfg_half,
  input  logic              cfg_direct,
  input  logic              cfg_tx_fixed,
  input  logic              cfg_csma,
  input  logic              cfg_cbus_en,
  input  logic              tx_bit,
  output logic              tx_req,
  output logic              rx_bit,
  output logic              rx_stb,
  input  logic              mx_out6,
  input  logic              mx_out7,
  output logic              mx_in6,
  input  logic              pin_din,
  output logic              pin_dout,
  input  logic              echo_in,
  output logic              cbus_pd,
  output logic              collision
);

  logic            started_q, par_q;
  logic [BITS-1:0] rep_q;

  logic cur_started, cur_par, in_bit, active, replay, tx_d, cbus_ok;

  assign cur_started = started_q | fsync;
  assign cur_par     = fsync ? (started_q & ~par_q) : par_q;

  assign in_bit = cur_started && (slot_idx == cfg_slot) && cfg_mask[bit_idx];
  assign active = in_bit && !(cfg_half && cur_par);
  assign replay = in_bit && cfg_half && cur_par;
  assign tx_d   = replay ? rep_q[bit_idx] : tx_bit;

  assign tx_req = active;
  assign rx_stb = active;
  assign rx_bit = cfg_direct ? pin_din : mx_out6;

  assign mx_in6   = (in_bit && (cfg_tx_fixed || !cfg_direct)) ? tx_d : 1'b1;
  assign pin_dout = (in_bit && cfg_direct) ? tx_d : mx_out7;

  assign cbus_ok   = cfg_csma || cfg_cbus_en;
  assign cbus_pd   = in_bit && cbus_ok && !tx_d;
  assign collision = in_bit && cfg_csma && (echo_in != tx_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      par_q     <= 1'b0;
      rep_q     <= '0;
    end else begin
      if (fsync) begin
        started_q <= 1'b1;
        par_q     <= cur_par;
      end
      if (active) rep_q[bit_idx] <= tx_bit;
    end
  end

endmodule

module tdm_subchan_gate_chk #(
  parameter int SLOT_W = 5,
  parameter int BITS   = 8,
  parameter int BIT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SLOT_W-1:0] slot_idx,
  input logic [BIT_W-1:0]  bit_idx,
  input logic [SLOT_W-1:0] cfg_slot,
  input logic [BITS-1:0]   cfg_mask,
  input logic              cfg_csma,
  input logic              cfg_cbus_en,
  input logic              rx_stb,
  input logic              tx_req,
  input logic              mx_out7,
  input logic              pin_dout,
  input logic              cbus_pd,
  input logic              collision
);
  logic valid_pos;
  assign valid_pos = (slot_idx == cfg_slot) && cfg_mask[bit_idx];

  // R2
  stb_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stb || tx_req) |-> valid_pos);

  // R9
  cbus_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_csma && !cfg_cbus_en) |-> !cbus_pd);

  // R10
  no_collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_csma |-> !collision);

  // R7
  pin_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_pos |-> (pin_dout == mx_out7));

  // R9
  cbus_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cbus_pd |-> valid_pos);
endmodule

bind tdm_subchan_gate tdm_subchan_gate_chk #(.SLOT_W(SLOT_W), .BITS(BITS), .BIT_W(BIT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_idx(slot_idx), .bit_idx(bit_idx),
  .cfg_slot(cfg_slot), .cfg_mask(cfg_mask), .cfg_csma(cfg_csma),
  .cfg_cbus_en(cfg_cbus_en), .rx_stb(rx_stb), .tx_req(tx_req),
  .mx_out7(mx_out7), .pin_dout(pin_dout), .cbus_pd(cbus_pd),
  .collision(collision)
);

// File: tb/tb_tdm_subchan_gate.sv
module tb_tdm_subchan_gate;
  localparam int SLOTS = 4;
  localparam int BITS  = 8;
  localparam int SW = $clog2(SLOTS);
  localparam int BW = $clog2(BITS);

  logic clk = 0, rst_n = 0, fsync = 0;
  logic [SW-1:0] slot_idx = '0, cfg_slot = '0;
  logic [BW-1:0] bit_idx = '0;
  logic [BITS-1:0] cfg_mask = '1;
  logic cfg_half = 0, cfg_direct = 0, cfg_tx_fixed = 0, cfg_csma = 0, cfg_cbus_en = 0;
  logic tx_bit = 0, mx_out6 = 0, mx_out7 = 0, pin_din = 0, echo_in = 0;
  logic tx_req, rx_bit, rx_stb, mx_in6, pin_dout, cbus_pd, collision;

  int errors = 0, checks = 0, frame = -1;
  logic [BITS-1:0] rep = '0;

  always #4 clk = ~clk;

  tdm_subchan_gate #(.SLOTS(SLOTS), .BITS(BITS)) dut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .slot_idx(slot_idx), .bit_idx(bit_idx),
    .cfg_slot(cfg_slot), .cfg_mask(cfg_mask), .cfg_half(cfg_half), .cfg_direct(cfg_direct),
    .cfg_tx_fixed(cfg_tx_fixed), .cfg_csma(cfg_csma), .cfg_cbus_en(cfg_cbus_en),
    .tx_bit(tx_bit), .tx_req(tx_req), .rx_bit(rx_bit), .rx_stb(rx_stb),
    .mx_out6(mx_out6), .mx_out7(mx_out7), .mx_in6(mx_in6), .pin_din(pin_din),
    .pin_dout(pin_dout), .echo_in(echo_in), .cbus_pd(cbus_pd), .collision(collision));

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s t=%0t got=%b exp=%b", tag, $time, got, exp);
    end
  endtask

  task automatic drive(input int s, input int b);
    @(negedge clk);
    slot_idx = SW'(s);
    bit_idx  = BW'(b);
    fsync    = (s == 0 && b == 0) && (frame >= -1);
    tx_bit   = 1'($urandom);
    mx_out6  = 1'($urandom);
    mx_out7  = 1'($urandom);
    pin_din  = 1'($urandom);
    echo_in  = 1'($urandom);
    #1;
  endtask

  task automatic step(input int s, input int b);
    logic in_bit, odd, act, txd;
    drive(s, b);
    if (fsync) frame++;
    odd    = frame[0];
    in_bit = (s == int'(cfg_slot)) && cfg_mask[b];
    act    = in_bit && !(cfg_half && odd);
    txd    = (in_bit && cfg_half && odd) ? rep[b] : tx_bit;
    if (cfg_half) begin
      chk(tx_req, act, "R4 tx_req");
      chk(rx_stb, act, "R4 rx_stb");
    end else begin
      chk(tx_req, act, "R3 tx_req");
      chk(rx_stb, act, "R3 rx_stb");
    end
    if (act) chk(rx_bit, cfg_direct ? pin_din : mx_out6, "R6 rx_bit");
    if (in_bit && cfg_half && odd)
      chk(cfg_direct ? pin_dout : mx_in6, rep[b], "R5 replay");
    chk(pin_dout, (in_bit && cfg_direct) ? txd : mx_out7, "R7 pin_dout");
    chk(mx_in6, (in_bit && (cfg_tx_fixed || !cfg_direct)) ? txd : 1'b1, "R8 mx_in6");
    chk(cbus_pd, in_bit && (cfg_csma || cfg_cbus_en) && !txd, "R9 cbus_pd");
    chk(collision, in_bit && cfg_csma && (echo_in != txd), "R10 collision");
    if (!in_bit) chk(tx_req | rx_stb, 1'b0, "R2 outside validated");
    if (act) rep[b] = tx_bit;
  endtask

  initial begin : main
    frame = -2;
    repeat (3) begin
      drive(0, 0);
      chk(rx_stb | tx_req | cbus_pd, 1'b0, "R1 in reset");
      chk(mx_in6, 1'b1, "R1 mx_in6 in reset");
    end
    @(negedge clk); rst_n = 1;
    cfg_slot = 0; cfg_mask = '1; cfg_csma = 1; cfg_cbus_en = 1;
    for (int b = 0; b < BITS; b++) begin
      drive(0, b);
      fsync = 0;
      #1;
      chk(rx_stb | tx_req | cbus_pd | collision, 1'b0, "R1 before first sync");
      chk(pin_dout, mx_out7, "R1 pin_dout before sync");
      chk(mx_in6, 1'b1, "R1 mx_in6 before sync");
    end
    frame = -1;
    for (int ci = 0; ci < 32; ci++) begin
      for (int mi = 0; mi < 5; mi++) begin
        logic [BITS-1:0] m;
        case (mi)
          0: m = 8'hFF; 1: m = 8'hA5; 2: m = 8'h01; 3: m = 8'h80; default: m = 8'h00;
        endcase
        @(negedge clk);
        cfg_half = ci[0]; cfg_direct = ci[1]; cfg_tx_fixed = ci[2];
        cfg_csma = ci[3]; cfg_cbus_en = ci[4];
        cfg_mask = m; cfg_slot = SW'((ci + mi) % SLOTS);
        for (int f = 0; f < 4; f++)
          for (int s = 0; s < SLOTS; s++)
            for (int b = 0; b < BITS; b++)
              step(s, b);
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : watchdog
    #(8 * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule